// File: doc/BRIEF.md
# Lockable Temperature Sensor Register File

This block holds the register set of a digital temperature sensor: a capability word, a configuration word, three temperature limits (upper alarm, lower alarm, critical), the latest temperature sample with its trip flags, and two fixed identification words. The serial-bus front end hands it committed writes (address, data, one-cycle enable), and it returns read data for any address on a combinational read port. The event evaluator outside this block takes the decoded configuration fields and the three limit values from dedicated output ports. It supplies the event assertion state back, and that state appears as a read-only status bit.

Write permission depends on state. The configuration word has two sticky lock bits that only reset can clear. The critical lock protects the critical limit. The alarm lock protects the upper and lower limits. While either lock is set, the hysteresis, output-enable, polarity and mode fields are frozen, and the sensor cannot be put into shutdown, although it can still be taken out of shutdown. The critical-only select cannot be raised while the critical lock holds. A write of 1 to the clear bit produces a single-cycle clear pulse towards the event logic, and that bit never reads back as 1.

The temperature word captures the 13-bit sample and the three trip flags on every valid sample strobe, except while shutdown is set. In shutdown the last captured value stays frozen.

Top module: `thermo_regfile`

## Requirements
- R1: Reads are combinational. Address 0 gives capability, 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit, 5 temperature word, 6 manufacturer word and 7 device word. Any address of 8 or above reads 0x0000.
- R2: After reset the reads return 0x007F at address 0, 0x0000 at addresses 1 through 5, 0x1B09 at address 6 and 0x0813 at address 7.
- R3: Configuration bit 7 (critical lock) and bit 6 (alarm lock) are set by writing 1. Writing 0 does not clear them; only reset does. While bit 7 is set, writes to address 4 are ignored. While bit 6 is set, writes to addresses 2 and 3 are ignored.
- R4: While either lock bit is set, configuration bits 10:9 (hysteresis select), bit 3 (output enable), bit 1 (polarity) and bit 0 (mode) keep their value on any write. The lock state used is the one held before the write.
- R5: Configuration bit 8 (shutdown) can be cleared by any write with bit 8 = 0. It cannot go from 0 to 1 while either lock bit is set.
- R6: Configuration bit 2 (critical-only select) cannot go from 0 to 1 while bit 7 is set. Otherwise it follows the written value.
- R7: A configuration write with bit 5 = 1 drives clear_pulse high for exactly the one cycle after the write edge. Bit 5 always reads 0.
- R8: Configuration read bit 4 equals the event_active input in the same cycle. Writes to bit 4 have no effect.
- R9: Configuration bits 15:11 read 0 whatever is written. Limit bits 15:13 and 1:0 read 0 whatever is written.
- R10: Writes to addresses 0, 5, 6, 7 and to any address of 8 or above change no register. This includes addresses whose low three bits alias a writable one.
- R11: On a sample strobe with shutdown clear, the temperature word becomes {crit flag, high flag, low flag, 13-bit sample}, placed in bits 15, 14, 13 and 12:0. While shutdown is set, strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Committed write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| smp_vld | input | 1 | New temperature sample strobe |
| smp_temp | input | 13 | Two's complement sample |
| smp_crit | input | 1 | Sample at or above critical limit |
| smp_high | input | 1 | Sample above upper limit |
| smp_low | input | 1 | Sample below lower limit |
| event_active | input | 1 | Event assertion state from the evaluator |
| hyst_sel | output | 2 | Hysteresis select field |
| shutdown | output | 1 | Shutdown field |
| crit_lock | output | 1 | Critical lock field |
| alarm_lock | output | 1 | Alarm lock field |
| clear_pulse | output | 1 | One-cycle event clear request |
| event_en | output | 1 | Event output enable field |
| crit_only | output | 1 | Critical-only select field |
| event_pol | output | 1 | Event polarity field |
| event_mode | output | 1 | Event mode field (0 comparator, 1 interrupt) |
| high_limit | output | 16 | Upper alarm limit |
| low_limit | output | 16 | Lower alarm limit |
| critical_limit | output | 16 | Critical limit |

## Verification
On every cycle, the assertions check the state-dependent rules: the lock bits never fall outside reset, a locked limit and the frozen configuration fields hold their values, shutdown and critical-only never rise under their locks, a clear pulse always traces back to a write of the clear bit, and the temperature word stays still during shutdown. Only the directed scenarios can show the actual values. These include the reset contents, the masking of reserved bits, the fixed identification words, the zero reads of unmapped addresses, the live event mirror, and the fact that aliased and read-only writes leave every register untouched.

// File: rtl/tsreg_pkg.sv
package tsreg_pkg;

    localparam int REG_W  = 16;
    localparam int TEMP_W = 13;
    localparam int NUM_REGS = 8;
    localparam int NUM_LIMITS = 3;

    // Register slots; the numbering is decoded by the serial front end.
    typedef enum logic [2:0] {
        SLOT_CAP  = 3'd0,
        SLOT_CFG  = 3'd1,
        SLOT_HIGH = 3'd2,
        SLOT_LOW  = 3'd3,
        SLOT_CRIT = 3'd4,
        SLOT_TEMP = 3'd5,
        SLOT_MFG  = 3'd6,
        SLOT_DEV  = 3'd7
    } reg_slot_e;

    // Stored configuration state (status and clear bits are not stored).
    typedef struct packed {
        logic [1:0] hyst;
        logic       shdn;
        logic       crit_lock;
        logic       alarm_lock;
        logic       evt_en;
        logic       crit_only;
        logic       evt_pol;
        logic       evt_mode;
    } cfg_t;

    // Writable bits of a limit word: 0.25 degree granularity, sign in bit 12.
    localparam logic [REG_W-1:0] LIMIT_KEEP = 16'h1FFC;

    function automatic logic [REG_W-1:0] cfg_word(cfg_t c, logic evt);
        return {5'b0, c.hyst, c.shdn, c.crit_lock, c.alarm_lock,
                1'b0, evt, c.evt_en, c.crit_only, c.evt_pol, c.evt_mode};
    endfunction

endpackage

// File: rtl/tsreg_cfg.sv
module tsreg_cfg
    import tsreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg_q,
    output logic             clr_q
);

    cfg_t cfg_d;
    logic locked_any;

    assign locked_any = cfg_q.crit_lock | cfg_q.alarm_lock;

    always_comb begin
        cfg_d = cfg_q;
        cfg_d.crit_lock  = cfg_q.crit_lock  | wr_data[7];
        cfg_d.alarm_lock = cfg_q.alarm_lock | wr_data[6];
        if (!locked_any) begin
            cfg_d.hyst     = wr_data[10:9];
            cfg_d.evt_en   = wr_data[3];
            cfg_d.evt_pol  = wr_data[1];
            cfg_d.evt_mode = wr_data[0];
        end
        cfg_d.shdn      = wr_data[8] & (cfg_q.shdn | ~locked_any);
        cfg_d.crit_only = wr_data[2] & (cfg_q.crit_only | ~cfg_q.crit_lock);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= wr_hit & wr_data[5];
            if (wr_hit) cfg_q <= cfg_d;
        end
    end

    p_crit_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_q.crit_lock |=> cfg_q.crit_lock);
    p_alarm_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_q.alarm_lock |=> cfg_q.alarm_lock);
    p_fields_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.crit_lock || cfg_q.alarm_lock) |=>
        ($stable(cfg_q.hyst) && $stable(cfg_q.evt_en) &&
         $stable(cfg_q.evt_pol) && $stable(cfg_q.evt_mode)));
    p_no_shdn_entry_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.crit_lock || cfg_q.alarm_lock) && !cfg_q.shdn) |=> !cfg_q.shdn);
    p_crit_only_held_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.crit_lock && !cfg_q.crit_only) |=> !cfg_q.crit_only);
    p_clear_origin_r7: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> $past(wr_hit && wr_data[5]));

endmodule

// File: rtl/tsreg_limit.sv
module tsreg_limit
    import tsreg_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP = LIMIT_KEEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic             lock,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] value_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (wr_hit && !lock) begin
            value_q <= wr_data & KEEP;
        end
    end

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(value_q));
    p_rsvd_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (value_q & ~KEEP) == '0);

endmodule

// File: rtl/tsreg_rdmux.sv
module tsreg_rdmux
    import tsreg_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [REG_W-1:0] CAP_VALUE = 16'h007F,
    parameter logic [REG_W-1:0] MFG_VALUE = 16'h1B09,
    parameter logic [REG_W-1:0] DEV_VALUE = 16'h0813
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  cfg_rd,
    input  logic [REG_W-1:0]  lim_rd [NUM_LIMITS],
    input  logic [REG_W-1:0]  temp_rd,
    output logic [REG_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS - 1);

    reg_slot_e slot;
    assign slot = reg_slot_e'(rd_addr[2:0]);

    always_comb begin
        rd_data = '0;
        if (rd_addr <= TOP_ADDR) begin
            unique case (slot)
                SLOT_CAP:  rd_data = CAP_VALUE;
                SLOT_CFG:  rd_data = cfg_rd;
                SLOT_HIGH: rd_data = lim_rd[0];
                SLOT_LOW:  rd_data = lim_rd[1];
                SLOT_CRIT: rd_data = lim_rd[2];
                SLOT_TEMP: rd_data = temp_rd;
                SLOT_MFG:  rd_data = MFG_VALUE;
                SLOT_DEV:  rd_data = DEV_VALUE;
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/thermo_regfile.sv
module thermo_regfile
    import tsreg_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [REG_W-1:0] CAP_VALUE = 16'h007F,
    parameter logic [REG_W-1:0] MFG_VALUE = 16'h1B09,
    parameter logic [REG_W-1:0] DEV_VALUE = 16'h0813
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic              smp_vld,
    input  logic [12:0]       smp_temp,
    input  logic              smp_crit,
    input  logic              smp_high,
    input  logic              smp_low,
    input  logic              event_active,
    output logic [1:0]        hyst_sel,
    output logic              shutdown,
    output logic              crit_lock,
    output logic              alarm_lock,
    output logic              clear_pulse,
    output logic              event_en,
    output logic              crit_only,
    output logic              event_pol,
    output logic              event_mode,
    output logic [15:0]       high_limit,
    output logic [15:0]       low_limit,
    output logic [15:0]       critical_limit
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(SLOT_CFG);
    localparam int                LIM_BASE = int'(SLOT_HIGH);

    cfg_t             cfg_q;
    logic             clr_q;
    logic [REG_W-1:0] lim_q [NUM_LIMITS];
    logic [REG_W-1:0] temp_q;
    logic [REG_W-1:0] cfg_rd;

    tsreg_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_en && (wr_addr == CFG_ADDR)),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .clr_q   (clr_q)
    );

    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(LIM_BASE + g);
        logic lock_sel;
        if (g == NUM_LIMITS - 1) begin : g_crit
            assign lock_sel = cfg_q.crit_lock;
        end else begin : g_alarm
            assign lock_sel = cfg_q.alarm_lock;
        end
        tsreg_limit #(.KEEP(LIMIT_KEEP)) u_lim (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_en && (wr_addr == MY_ADDR)),
            .lock    (lock_sel),
            .wr_data (wr_data),
            .value_q (lim_q[g])
        );
    end

    // Temperature word: trip flags above the 13-bit sample, frozen in shutdown.
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else if (smp_vld && !cfg_q.shdn) begin
            temp_q <= {smp_crit, smp_high, smp_low, smp_temp};
        end
    end

    assign cfg_rd = cfg_word(cfg_q, event_active);

    tsreg_rdmux #(
        .ADDR_W    (ADDR_W),
        .CAP_VALUE (CAP_VALUE),
        .MFG_VALUE (MFG_VALUE),
        .DEV_VALUE (DEV_VALUE)
    ) u_rdmux (
        .rd_addr (rd_addr),
        .cfg_rd  (cfg_rd),
        .lim_rd  (lim_q),
        .temp_rd (temp_q),
        .rd_data (rd_data)
    );

    assign hyst_sel       = cfg_q.hyst;
    assign shutdown       = cfg_q.shdn;
    assign crit_lock      = cfg_q.crit_lock;
    assign alarm_lock     = cfg_q.alarm_lock;
    assign clear_pulse    = clr_q;
    assign event_en       = cfg_q.evt_en;
    assign crit_only      = cfg_q.crit_only;
    assign event_pol      = cfg_q.evt_pol;
    assign event_mode     = cfg_q.evt_mode;
    assign high_limit     = lim_q[0];
    assign low_limit      = lim_q[1];
    assign critical_limit = lim_q[2];

    p_temp_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> $stable(temp_q));
    p_cfg_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == CFG_ADDR) |-> (rd_data[15:11] == 5'd0 && !rd_data[5]));
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > ADDR_W'(NUM_REGS - 1)) |-> (rd_data == 16'h0000));

endmodule

// File: tb/thermo_regfile_tb_top.sv
module thermo_regfile_tb_top;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          smp_vld = 1'b0;
    logic [12:0]   smp_temp = '0;
    logic          smp_crit = 1'b0, smp_high = 1'b0, smp_low = 1'b0;
    logic          event_active = 1'b0;
    logic [1:0]    hyst_sel;
    logic          shutdown, crit_lock, alarm_lock, clear_pulse;
    logic          event_en, crit_only, event_pol, event_mode;
    logic [15:0]   high_limit, low_limit, critical_limit;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    thermo_regfile #(.ADDR_W(AW)) dut_i (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .smp_vld, .smp_temp, .smp_crit, .smp_high, .smp_low, .event_active,
        .hyst_sel, .shutdown, .crit_lock, .alarm_lock, .clear_pulse,
        .event_en, .crit_only, .event_pol, .event_mode,
        .high_limit, .low_limit, .critical_limit
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sample(input logic [12:0] t, input logic c, input logic h, input logic l);
        @(negedge clk);
        smp_vld = 1'b1; smp_temp = t; smp_crit = c; smp_high = h; smp_low = l;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        read_chk("R2 cap", 8'd0, 16'h007F);
        read_chk("R2 cfg", 8'd1, 16'h0000);
        read_chk("R2 high", 8'd2, 16'h0000);
        read_chk("R2 low", 8'd3, 16'h0000);
        read_chk("R2 crit", 8'd4, 16'h0000);
        read_chk("R2 temp", 8'd5, 16'h0000);
        read_chk("R2 mfg", 8'd6, 16'h1B09);
        read_chk("R2 dev", 8'd7, 16'h0813);
        read_chk("R1 addr8", 8'd8, 16'h0000);
        read_chk("R1 addrFF", 8'hFF, 16'h0000);
        check("R2 clear_pulse", {15'd0, clear_pulse}, 16'h0000);
    endtask

    task automatic t_limit_masks();
        do_reset();
        wr(8'd2, 16'hFFFF);
        wr(8'd3, 16'h1C90);
        wr(8'd4, 16'h0503);
        read_chk("R9 high masked", 8'd2, 16'h1FFC);
        read_chk("R1 low", 8'd3, 16'h1C90);
        read_chk("R9 crit masked", 8'd4, 16'h0500);
        check("R1 high port", high_limit, 16'h1FFC);
        check("R1 crit port", critical_limit, 16'h0500);
    endtask

    task automatic t_cfg_and_clear();
        do_reset();
        wr(8'd1, 16'h072F);
        check("R7 pulse high", {15'd0, clear_pulse}, 16'h0001);
        read_chk("R7 cfg readback", 8'd1, 16'h070F);
        check("R4 field ports", {8'd0, hyst_sel, shutdown, event_en, crit_only, event_pol, event_mode, 1'b0},
              16'h00FE);
        @(negedge clk);
        check("R7 pulse one cycle", {15'd0, clear_pulse}, 16'h0000);
        event_active = 1'b1;
        read_chk("R8 mirror on", 8'd1, 16'h071F);
        wr(8'd1, 16'h0010);
        read_chk("R8 write ignored", 8'd1, 16'h0010);
        event_active = 1'b0;
        read_chk("R8 mirror off", 8'd1, 16'h0000);
        wr(8'd1, 16'hF800);
        read_chk("R9 cfg rsvd", 8'd1, 16'h0000);
    endtask

    task automatic t_alarm_lock();
        do_reset();
        wr(8'd2, 16'h0100);
        wr(8'd1, 16'h0040);
        read_chk("R3 alarm lock set", 8'd1, 16'h0040);
        wr(8'd2, 16'h0200);
        read_chk("R3 high locked", 8'd2, 16'h0100);
        wr(8'd3, 16'h0200);
        read_chk("R3 low locked", 8'd3, 16'h0000);
        wr(8'd4, 16'h0300);
        read_chk("R3 crit open", 8'd4, 16'h0300);
        wr(8'd1, 16'h0000);
        read_chk("R3 lock sticky", 8'd1, 16'h0040);
        wr(8'd1, 16'h070F);
        read_chk("R4 R5 R6 locked cfg", 8'd1, 16'h0044);
    endtask

    task automatic t_crit_lock_shutdown();
        do_reset();
        wr(8'd1, 16'h0100);
        read_chk("R5 shutdown set", 8'd1, 16'h0100);
        wr(8'd1, 16'h0180);
        read_chk("R3 crit lock set", 8'd1, 16'h0180);
        wr(8'd1, 16'h0080);
        read_chk("R5 shutdown cleared", 8'd1, 16'h0080);
        wr(8'd1, 16'h0104);
        read_chk("R5 R6 blocked", 8'd1, 16'h0080);
        wr(8'd4, 16'h0400);
        read_chk("R3 crit locked", 8'd4, 16'h0000);
        wr(8'd2, 16'h0400);
        read_chk("R3 high open", 8'd2, 16'h0400);
    endtask

    task automatic t_ignored_writes();
        do_reset();
        wr(8'd0, 16'hFFFF);
        wr(8'd5, 16'hFFFF);
        wr(8'd6, 16'hFFFF);
        wr(8'd7, 16'hFFFF);
        wr(8'd8, 16'hFFFF);
        wr(8'h09, 16'hFFFF);
        wr(8'h0A, 16'hFFFF);
        wr(8'hFC, 16'hFFFF);
        read_chk("R10 cap", 8'd0, 16'h007F);
        read_chk("R10 cfg", 8'd1, 16'h0000);
        read_chk("R10 high", 8'd2, 16'h0000);
        read_chk("R10 crit", 8'd4, 16'h0000);
        read_chk("R10 temp", 8'd5, 16'h0000);
        read_chk("R10 mfg", 8'd6, 16'h1B09);
        read_chk("R10 dev", 8'd7, 16'h0813);
    endtask

    task automatic t_temperature();
        do_reset();
        sample(13'h1C90, 1'b0, 1'b0, 1'b1);
        read_chk("R11 capture", 8'd5, 16'h3C90);
        wr(8'd1, 16'h0100);
        sample(13'h0190, 1'b0, 1'b1, 1'b0);
        read_chk("R11 frozen", 8'd5, 16'h3C90);
        wr(8'd1, 16'h0000);
        sample(13'h0190, 1'b1, 1'b0, 1'b0);
        read_chk("R11 resumed", 8'd5, 16'h8190);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_limit_masks();
        t_cfg_and_clear();
        t_alarm_lock();
        t_crit_lock_shutdown();
        t_ignored_writes();
        t_temperature();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule